// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three 16-bit down-counters behind a four-byte, byte-wide register window. Software first writes a control byte. The byte picks a counter, how the counter's 16-bit reload value is reached through an 8-bit port, and the counter's operating mode. Software then writes the reload value into that counter's port one byte at a time. Each counter decrements on every pulse of a count-enable input that comes from a fixed timebase. When a counter reaches terminal count it reloads itself.

Every counter drives one output whose waveform depends on its mode. The mode can be a one-period low pulse (rate generator), a near-even square wave, or a level that rises at terminal count. Counter 0 also drives an interrupt request, but only in the terminal-count mode. The request stays asserted until it is acknowledged. Typical use is a periodic tick for system software, with counters 1 and 2 acting as free-running dividers.

Top module: `triple_interval_timer`

## Requirements
- R1: Offsets 0, 1 and 2 reach counters 0, 1 and 2, and offset 3 is the control byte. A read of offset 3 returns the last control byte written, unchanged.
- R2: The control byte fields are: counter select in bits 7:6, access style in bits 5:4, mode in bits 3:1, and bit 0 stored but unused. A select value of 3 addresses counter 0. Mode value 0 is terminal-count interrupt, 2 is rate generator and 3 is square wave.
- R3: Access style 1 (low only) writes reload bits 7:0 and keeps bits 15:8. Style 2 (high only) writes bits 15:8 and keeps bits 7:0.
- R4: Access style 3 (word) uses the low byte on the first counter-port access, whether read or write, after a control write. Every later counter access uses the high byte until the next control write.
- R5: A counter read returns the reload byte chosen by the current style. Under style 0, counter writes change nothing and counter reads return 0.
- R6: A high-byte write loads the full reload value into the count and restarts counting from it, even mid-period. With reload N > 0, terminal count happens on the Nth count-enable pulse after the load, and the count then reloads N. With reload 0 the counter does not run and its output stays high.
- R7: In rate-generator mode the output is low exactly while the count equals 1, which is one count period in every N.
- R8: In square-wave mode the output is high for ceil(N/2) count periods and low for floor(N/2) count periods.
- R9: In terminal-count mode the output is low after a control write or a load, goes high at the next terminal count, and stays high.
- R10: After reset every counter is in rate-generator mode with reload 0, all outputs are high, the interrupt is low and the control byte reads 0.
- R11: The interrupt sets when counter 0 reaches terminal count in terminal-count mode, and never in any other mode. It holds until irq_ack. A terminal count in the same cycle as irq_ack leaves it set. A control write that selects counter 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (advances word sequencing) |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| count_en | input | 1 | One-cycle timebase pulse, one count per pulse |
| irq_ack | input | 1 | Clears a pending interrupt |
| timer_out | output | NUM_CH | Per-counter output waveform |
| irq | output | 1 | Interrupt request from counter 0 |

## Verification
The bench targets the low/high byte sequencing of word style, including that reads also advance it. A design that reset the sequence after the high byte, or ignored reads, would return the wrong byte at the second read. It checks that a reload restarts counting mid-period: a design that only updated the reload register would pulse the rate output one period early. It also drives terminal count and acknowledge in the same cycle and expects the request to stay set. Finally, select value 3 must reach counter 0, and rate mode must never interrupt. A design that got these wrong would lose interrupts or raise false ones.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      ACC_NONE = 2'b00,
      ACC_LO   = 2'b01,
      ACC_HI   = 2'b10,
      ACC_WORD = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      K_TERM,
      K_RATE,
      K_SQUARE
   } kind_e;

   typedef struct packed {
      logic [1:0] sel;
      acc_e       acc;
      logic [2:0] mode;
      logic       bcd;
   } ctrl_t;

   function automatic kind_e mode_kind(input logic [2:0] m);
      if (m == 3'd0)
         return K_TERM;
      else if (m[1:0] == 2'b11)
         return K_SQUARE;
      else
         return K_RATE;
   endfunction
endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              addr,
   input  logic [BYTE_W-1:0]       wdata,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [NUM_CH*CNT_W-1:0] reload_all,
   output logic [BYTE_W-1:0]       rdata,
   output logic [NUM_CH-1:0]       wr_lo,
   output logic [NUM_CH-1:0]       wr_hi,
   output logic [NUM_CH-1:0]       cfg_set,
   output logic [2:0]              cfg_mode
);
   localparam logic [1:0] CTRL_OFS = 2'd3;

   ctrl_t      ctrl_q;
   logic       hi_phase_q;
   ctrl_t      wctrl;
   logic [1:0] wsel;
   logic       is_ctrl;
   logic       ctr_hit;
   logic       use_hi;
   logic       byte_ok;

   assign wctrl    = ctrl_t'(wdata);
   assign wsel     = (wctrl.sel == 2'd3) ? 2'd0 : wctrl.sel;
   assign cfg_mode = wctrl.mode;
   assign is_ctrl  = (addr == CTRL_OFS);
   assign ctr_hit  = !is_ctrl && (int'(addr) < NUM_CH);
   assign byte_ok  = (ctrl_q.acc != ACC_NONE);

   always_comb begin
      case (ctrl_q.acc)
         ACC_HI:   use_hi = 1'b1;
         ACC_WORD: use_hi = hi_phase_q;
         default:  use_hi = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         hi_phase_q <= 1'b0;
      end else if (wr_en && is_ctrl) begin
         ctrl_q     <= wctrl;
         hi_phase_q <= 1'b0;
      end else if ((wr_en || rd_en) && ctr_hit && ctrl_q.acc == ACC_WORD) begin
         hi_phase_q <= 1'b1;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      logic hit;
      assign hit        = ctr_hit && (addr == 2'(c));
      assign wr_lo[c]   = wr_en && hit && byte_ok && !use_hi;
      assign wr_hi[c]   = wr_en && hit && byte_ok && use_hi;
      assign cfg_set[c] = wr_en && is_ctrl && (wsel == 2'(c));
   end

   always_comb begin
      rdata = '0;
      if (is_ctrl) begin
         rdata = ctrl_q;
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (ctr_hit && byte_ok && addr == 2'(c))
               rdata = use_hi ? reload_all[c*CNT_W+BYTE_W +: BYTE_W]
                              : reload_all[c*CNT_W +: BYTE_W];
         end
      end
   end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              cfg_set,
   input  logic [2:0]        cfg_mode,
   input  logic [BYTE_W-1:0] wdata,
   output logic [CNT_W-1:0]  reload_o,
   output logic              is_term_o,
   output logic              tc_o,
   output logic              out_o
);
   localparam int HALF = CNT_W / 2;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] cnt_q;
   logic [2:0]       mode_q;
   logic             tc_seen_q;
   logic             active;
   logic             at_end;
   kind_e            kind;

   assign active    = (reload_q != '0);
   assign at_end    = (cnt_q <= ONE);
   assign tc_o      = tick && active && at_end && !wr_hi;
   assign kind      = mode_kind(mode_q);
   assign is_term_o = (kind == K_TERM);
   assign reload_o  = reload_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q  <= '0;
         cnt_q     <= '0;
         mode_q    <= 3'd2;
         tc_seen_q <= 1'b0;
      end else begin
         if (wr_lo)
            reload_q[HALF-1:0] <= wdata;
         if (wr_hi) begin
            reload_q[CNT_W-1:HALF] <= wdata;
            cnt_q                  <= {wdata, reload_q[HALF-1:0]};
            tc_seen_q              <= 1'b0;
         end else if (tick && active) begin
            cnt_q <= at_end ? reload_q : cnt_q - ONE;
         end
         if (tc_o)
            tc_seen_q <= 1'b1;
         if (cfg_set) begin
            mode_q    <= cfg_mode;
            tc_seen_q <= 1'b0;
         end
      end
   end

   always_comb begin
      case (kind)
         K_TERM:   out_o = tc_seen_q;
         K_SQUARE: out_o = !active || (cnt_q > (reload_q >> 1));
         default:  out_o = !(active && cnt_q == ONE);
      endcase
   end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
   parameter int                NUM_CH   = 3,
   parameter logic [NUM_CH-1:0] IRQ_MASK = NUM_CH'(1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tc,
   input  logic [NUM_CH-1:0] is_term,
   input  logic [NUM_CH-1:0] cfg_set,
   input  logic              ack,
   output logic              irq
);
   logic [NUM_CH-1:0] pend_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
      logic arm;
      assign arm = tc[c] && is_term[c] && IRQ_MASK[c];
      always_ff @(posedge clk) begin
         if (!rst_n)
            pend_q[c] <= 1'b0;
         else if (cfg_set[c])
            pend_q[c] <= 1'b0;
         else if (arm)
            pend_q[c] <= 1'b1;
         else if (ack)
            pend_q[c] <= 1'b0;
      end
   end

   assign irq = |(pend_q & IRQ_MASK);
endmodule

// File: rtl/triple_interval_timer.sv
module triple_interval_timer
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [7:0]        bus_rdata,
   input  logic              count_en,
   input  logic              irq_ack,
   output logic [NUM_CH-1:0] timer_out,
   output logic              irq
);
   localparam int RL_W = NUM_CH * CNT_W;

   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("NUM_CH must be between 1 and 3");
   end
   if (CNT_W != 2 * BYTE_W) begin : g_bad_w
      $error("CNT_W must be twice the byte width");
   end

   logic [RL_W-1:0]   reload_all;
   logic [NUM_CH-1:0] wr_lo, wr_hi, cfg_set, tc, is_term;
   logic [2:0]        cfg_mode;

   tmr_regif #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_regif (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .wr_en      (bus_wr),
      .rd_en      (bus_rd),
      .reload_all (reload_all),
      .rdata      (bus_rdata),
      .wr_lo      (wr_lo),
      .wr_hi      (wr_hi),
      .cfg_set    (cfg_set),
      .cfg_mode   (cfg_mode)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tmr_channel #(.CNT_W(CNT_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (count_en),
         .wr_lo     (wr_lo[c]),
         .wr_hi     (wr_hi[c]),
         .cfg_set   (cfg_set[c]),
         .cfg_mode  (cfg_mode),
         .wdata     (bus_wdata),
         .reload_o  (reload_all[c*CNT_W +: CNT_W]),
         .is_term_o (is_term[c]),
         .tc_o      (tc[c]),
         .out_o     (timer_out[c])
      );
   end

   tmr_irq #(.NUM_CH(NUM_CH), .IRQ_MASK(NUM_CH'(1))) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .tc      (tc),
      .is_term (is_term),
      .cfg_set (cfg_set),
      .ack     (irq_ack),
      .irq     (irq)
   );
endmodule

// File: rtl/tmr_pit_chk.sv
module tmr_pit_chk #(
   parameter int NUM_CH = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        bus_addr,
   input logic [7:0]        bus_wdata,
   input logic              bus_wr,
   input logic [7:0]        bus_rdata,
   input logic              count_en,
   input logic              irq_ack,
   input logic [NUM_CH-1:0] timer_out,
   input logic              irq
);
   logic ch0_cfg;
   assign ch0_cfg = bus_wr && bus_addr == 2'd3 &&
                    (bus_wdata[7:6] == 2'd0 || bus_wdata[7:6] == 2'd3);

   assert_irq_from_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(count_en));

   assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !irq_ack && !ch0_cfg |=> irq);

   assert_ack_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq && irq_ack && !count_en && !ch0_cfg |=> !irq);

   assert_cfg_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ch0_cfg |=> !irq);

   assert_ctrl_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd3) ##1 (bus_addr == 2'd3 && !bus_wr)
      |-> bus_rdata == $past(bus_wdata));

   assert_out_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !count_en && !bus_wr |=> $stable(timer_out));

   assert_known_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown({irq, timer_out}));
endmodule

bind triple_interval_timer tmr_pit_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wr    (bus_wr),
   .bus_rdata (bus_rdata),
   .count_en  (count_en),
   .irq_ack   (irq_ack),
   .timer_out (timer_out),
   .irq       (irq)
);

// File: tb/triple_interval_timer_tb.sv
`timescale 1ns/1ps
module triple_interval_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       count_en = 1'b0;
   logic       irq_ack = 1'b0;
   logic [2:0] timer_out;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   triple_interval_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .count_en(count_en), .irq_ack(irq_ack), .timer_out(timer_out), .irq(irq)
   );

   // vector: {is_read, offset[1:0], data}; for reads data is the expected byte
   localparam logic [10:0] VEC [0:31] = '{
      11'h334, 11'h734,                    // R1 control write and readback
      11'h005, 11'h000, 11'h400, 11'h400,  // R4 word: low, high, then high stays
      11'h314, 11'h405, 11'h0AA, 11'h4AA,  // R3 low only
      11'h324, 11'h400, 11'h012, 11'h412,  // R3 high only
      11'h314, 11'h4AA,                    // R3 low byte kept
      11'h354, 11'h133, 11'h533, 11'h4AA,  // R3 counter 1 separate from 0
      11'h3D4, 11'h077, 11'h477, 11'h7D4,  // R2 select 3 reaches counter 0
      11'h304, 11'h099, 11'h400,           // R5 style 0 ignored, reads 0
      11'h314, 11'h477,                    // R5 reload unchanged
      11'h334, 11'h477, 11'h412            // R4 reads advance the sequence
   };
   localparam int VREQ [0:31] = '{1,1, 4,4,4,4, 3,3,3,3, 3,3,3,3, 3,3, 3,3,3,3,
                                  2,2,2,2, 5,5,5, 5,5, 4,4,4};

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic tick(input logic with_ack);
      @(negedge clk);
      count_en = 1'b1; irq_ack = with_ack;
      @(negedge clk);
      count_en = 1'b0; irq_ack = 1'b0;
      #1;
   endtask

   task automatic ack();
      @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      #1;
   endtask

   initial begin
      logic [7:0] d;
      do_reset();
      // R10 reset state
      #1;
      chk("R10 outputs", 16'(timer_out), 16'h7);
      chk("R10 irq", 16'(irq), 16'h0);
      rd(2'd3, d); chk("R10 control", 16'(d), 16'h0);
      rd(2'd0, d); chk("R10 counter read", 16'(d), 16'h0);

      for (int i = 0; i < 32; i++) begin
         if (VEC[i][10]) begin
            rd(VEC[i][9:8], d);
            chk($sformatf("R%0d table step %0d", VREQ[i], i), 16'(d), 16'(VEC[i][7:0]));
         end else begin
            wr(VEC[i][9:8], VEC[i][7:0]);
         end
      end

      do_reset();
      // R11 rate mode on counter 0 never interrupts; R7 with reload 2
      wr(2'd3, 8'h34); wr(2'd0, 8'h02); wr(2'd0, 8'h00);
      for (int i = 1; i <= 4; i++) begin
         tick(1'b0);
         chk("R11 no irq in rate mode", 16'(irq), 16'h0);
         chk("R7 reload 2", 16'(timer_out[0]), (i % 2 == 1) ? 16'h0 : 16'h1);
      end

      // R7 rate generator on counter 1, reload 4
      wr(2'd3, 8'h74); wr(2'd1, 8'h04); wr(2'd1, 8'h00);
      chk("R7 after load", 16'(timer_out[1]), 16'h1);
      for (int i = 1; i <= 8; i++) begin
         tick(1'b0);
         chk("R7 rate pattern", 16'(timer_out[1]), (i % 4 == 3) ? 16'h0 : 16'h1);
      end

      // R6 mid-period reload restarts the count
      tick(1'b0); tick(1'b0);
      wr(2'd3, 8'h74); wr(2'd1, 8'h04); wr(2'd1, 8'h00);
      tick(1'b0); chk("R6 restart tick1", 16'(timer_out[1]), 16'h1);
      tick(1'b0); chk("R6 restart tick2", 16'(timer_out[1]), 16'h1);
      tick(1'b0); chk("R6 restart tick3", 16'(timer_out[1]), 16'h0);

      // R6 reload 0 stops the counter
      wr(2'd3, 8'h74); wr(2'd1, 8'h00); wr(2'd1, 8'h00);
      for (int i = 0; i < 5; i++) begin
         tick(1'b0);
         chk("R6 reload zero", 16'(timer_out[1]), 16'h1);
      end

      // R8 square wave on counter 2, reload 5: 3 high, 2 low
      wr(2'd3, 8'hB6); wr(2'd2, 8'h05); wr(2'd2, 8'h00);
      chk("R8 after load", 16'(timer_out[2]), 16'h1);
      for (int i = 1; i <= 10; i++) begin
         tick(1'b0);
         chk("R8 square pattern", 16'(timer_out[2]),
             (i % 5 == 3 || i % 5 == 4) ? 16'h0 : 16'h1);
      end

      // R9 / R11 terminal-count mode on counter 0, selected with value 3 (R2)
      wr(2'd3, 8'hF0);
      #1;
      chk("R9 low after control", 16'(timer_out[0]), 16'h0);
      wr(2'd0, 8'h03); wr(2'd0, 8'h00);
      tick(1'b0); tick(1'b0);
      chk("R11 no irq before tc", 16'(irq), 16'h0);
      chk("R9 low before tc", 16'(timer_out[0]), 16'h0);
      tick(1'b0);
      chk("R11 irq at tc", 16'(irq), 16'h1);
      chk("R9 high at tc", 16'(timer_out[0]), 16'h1);
      for (int i = 0; i < 3; i++) begin
         tick(1'b0);
         chk("R11 irq held", 16'(irq), 16'h1);
      end
      ack();
      chk("R11 ack clears", 16'(irq), 16'h0);
      chk("R9 stays high", 16'(timer_out[0]), 16'h1);
      tick(1'b0); tick(1'b0);
      chk("R11 clear between tc", 16'(irq), 16'h0);
      tick(1'b1);
      chk("R11 tc beats ack", 16'(irq), 16'h1);
      wr(2'd3, 8'h30);
      #1;
      chk("R11 control write clears", 16'(irq), 16'h0);
      chk("R9 control write lowers", 16'(timer_out[0]), 16'h0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule